// File: doc/BRIEF.md
# ADC Burst Capture Controller

This block records a software-requested burst of 12-bit converter samples into a small synchronous FIFO. A downstream transfer engine drains that FIFO through a valid/ready stream. The core clock runs at twice the converter rate, so every sample is held on the input for two cycles. A data-select strobe marks the single cycle of each pair on which the sample may be taken. Samples arrive time-multiplexed, and each one carries a channel tag. A per-channel enable mask, latched when the burst is armed, decides which tags are kept.

Software arms a burst with a one-cycle start pulse, a sample count and the enable mask. The block then counts qualified samples until it reaches the programmed number and raises a done flag. Two sticky flags stay readable until the next accepted start. One records that the FIFO had no room for a sample. The other records that the converter marked a captured sample as out of range.

Top module: `adc_burst_capture`

## Requirements
- R1: After reset, st_busy, st_done, st_ovf, st_orng and m_valid are all 0.
- R2: A start pulse while idle latches the count and the enable mask. It clears st_done, st_ovf and st_orng and raises st_busy. All of these are visible after that clock edge.
- R3: A sample is taken only when the block is busy, adc_dsel is 1 and bit adc_ch of the latched mask is 1. Any other cycle (dsel low, a disabled channel, or idle) writes nothing. A stored word holds the sample in [11:0], the channel tag in [13:12] and zeros in [15:14].
- R4: On the edge that takes the programmed number of samples, st_busy falls and st_done rises. Every qualified sample counts toward that number, including one that is dropped.
- R5: A start with a count of 0 sets st_done and leaves st_busy at 0.
- R6: A start pulse while busy is ignored. The count, the mask and the flags keep their values.
- R7: A sample taken while the FIFO holds DEPTH entries is dropped and is never retried, and st_ovf is set. This holds even if a read happens on the same edge. st_ovf then stays 1 until the next accepted start.
- R8: A taken sample with adc_or high sets st_orng. st_orng stays 1 until the next accepted start. adc_or on a cycle that is not taken has no effect.
- R9: m_data and m_valid hold while m_valid is 1 and m_ready is 0. Words leave in the order they were taken.
- R10: A sample taken on a clock edge is presented on m_valid and m_data right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle burst start pulse |
| cmd_count | input | CNT_W | Number of samples to take |
| cmd_ch_en | input | CH_N | Channel enable mask, bit n enables tag n |
| adc_data | input | SAMPLE_W | Converter sample |
| adc_ch | input | CH_W | Channel tag of the sample |
| adc_dsel | input | 1 | Data-select strobe, high on the cycle to take |
| adc_or | input | 1 | Converter out-of-range indication |
| m_valid | output | 1 | Stream word available |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | WORD_W | Stream word |
| st_busy | output | 1 | Burst in progress |
| st_done | output | 1 | Burst completed |
| st_ovf | output | 1 | Sticky FIFO overflow |
| st_orng | output | 1 | Sticky converter out-of-range |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- The status flags change on the edge where the start or the qualifying strobe is seen.
- A taken word shows on the stream right after that same edge.
- A pop retires the head word on the edge where valid and ready are both high.

The bench changes inputs one nanosecond after the rising edge and reads outputs at the falling edge. Each check therefore sees exactly the state after the edge it targets. The stream monitor compares each accepted word in order against a list the bench builds from the stimulus.

// File: rtl/adc_burst_capture.sv
module adc_burst_capture #(
  parameter int SAMPLE_W = 12,
  parameter int CH_N     = 4,
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 8,
  parameter int WORD_W   = 16,
  localparam int CH_W    = $clog2(CH_N),
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_start,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [CH_N-1:0]     cmd_ch_en,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic [CH_W-1:0]     adc_ch,
  input  logic                adc_dsel,
  input  logic                adc_or,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [WORD_W-1:0]   m_data,
  output logic                st_busy,
  output logic                st_done,
  output logic                st_ovf,
  output logic                st_orng
);
  localparam int PAD_W = WORD_W - SAMPLE_W - CH_W;
  localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);

  logic [CNT_W-1:0]  left;
  logic [CH_N-1:0]   en;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [PTR_W:0]    level;

  wire go   = cmd_start & ~st_busy;
  wire qual = st_busy & adc_dsel & en[adc_ch];
  wire full = (level == FULL_LVL);
  wire push = qual & ~full;
  wire pop  = m_valid & m_ready;

  assign m_valid = (level != '0);
  assign m_data  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_busy <= 1'b0;
      st_done <= 1'b0;
      st_ovf  <= 1'b0;
      st_orng <= 1'b0;
      left    <= '0;
      en      <= '0;
    end else if (go) begin
      st_busy <= (cmd_count != '0);
      st_done <= (cmd_count == '0);
      st_ovf  <= 1'b0;
      st_orng <= 1'b0;
      left    <= cmd_count;
      en      <= cmd_ch_en;
    end else if (qual) begin
      left <= left - CNT_W'(1);
      if (full)   st_ovf  <= 1'b1;
      if (adc_or) st_orng <= 1'b1;
      if (left == CNT_W'(1)) begin
        st_busy <= 1'b0;
        st_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {{PAD_W{1'b0}}, adc_ch, adc_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + PTR_W'(1);
      if (pop)  rp <= rp + PTR_W'(1);
      case ({push, pop})
        2'b10:   level <= level + (PTR_W+1)'(1);
        2'b01:   level <= level - (PTR_W+1)'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

module adc_burst_capture_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic              st_busy,
  input logic              st_done,
  input logic              st_ovf,
  input logic              st_orng
);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovf && !(cmd_start && !st_busy)) |=> st_ovf);
  // R8
  orng_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_orng && !(cmd_start && !st_busy)) |=> st_orng);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !st_busy) |=> (!st_ovf && !st_orng));
  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !st_done);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R3
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_busy && !m_valid) |=> !m_valid);
endmodule

bind adc_burst_capture adc_burst_capture_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .st_busy(st_busy), .st_done(st_done),
  .st_ovf(st_ovf), .st_orng(st_orng)
);

// File: tb/test_adc_burst_capture.sv
`timescale 1ns/100ps
module test_adc_burst_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [15:0] cmd_count = '0;
  logic [3:0]  cmd_ch_en = '0;
  logic [11:0] adc_data = '0;
  logic [1:0]  adc_ch = '0;
  logic        adc_dsel = 1'b0;
  logic        adc_or = 1'b0;
  logic        m_ready = 1'b1;
  logic        m_valid, st_busy, st_done, st_ovf, st_orng;
  logic [15:0] m_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_w [256];
  int exp_n = 0;
  int rx_n  = 0;

  // fields: {enable[3:0], count[7:0], seed[11:0], or_index[7:0]}
  localparam logic [31:0] TABLE [5] = '{
    {4'hF, 8'd5, 12'h100, 8'hFF},
    {4'h5, 8'd4, 12'hABC, 8'd2},
    {4'h8, 8'd3, 12'hFFE, 8'd1},
    {4'h2, 8'd1, 12'h7F0, 8'hFF},
    {4'hF, 8'd7, 12'h000, 8'd6}
  };

  adc_burst_capture i_adc_burst_capture (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .cmd_ch_en(cmd_ch_en), .adc_data(adc_data), .adc_ch(adc_ch),
    .adc_dsel(adc_dsel), .adc_or(adc_or), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .st_busy(st_busy), .st_done(st_done), .st_ovf(st_ovf),
    .st_orng(st_orng)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start(input logic [15:0] cnt, input logic [3:0] en);
    cmd_start = 1'b1; cmd_count = cnt; cmd_ch_en = en;
    step();
    cmd_start = 1'b0;
  endtask

  task automatic send(input logic [1:0] ch, input logic [11:0] d, input logic o);
    adc_ch = ch; adc_data = d; adc_or = o; adc_dsel = 1'b1;
    step();
    adc_dsel = 1'b0;
    step();
    adc_or = 1'b0;
  endtask

  task automatic settle_check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    chk(req, act, exp);
  endtask

  // R9 stream order monitor
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (rx_n < exp_n) chk("R9 R3 stream word", {16'h0, m_data}, {16'h0, exp_w[rx_n]});
      else chk("R3 unexpected word", 32'h1, 32'h0);
      rx_n++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    @(negedge clk);
    chk("R1 busy", {31'h0, st_busy}, 0);
    chk("R1 done", {31'h0, st_done}, 0);
    chk("R1 ovf", {31'h0, st_ovf}, 0);
    chk("R1 orng", {31'h0, st_orng}, 0);
    chk("R1 valid", {31'h0, m_valid}, 0);
    rst_n = 1'b1;
    step();

    // table-driven bursts
    for (int t = 0; t < 5; t++) begin
      logic [3:0] en; logic [7:0] cnt; logic [11:0] seed; logic [7:0] ori;
      logic exp_or; int taken; int i;
      {en, cnt, seed, ori} = TABLE[t];
      exp_or = 1'b0; taken = 0; i = 0;
      start({8'h0, cnt}, en);
      @(negedge clk);
      chk("R2 busy after start", {31'h0, st_busy}, 1);
      chk("R2 done cleared", {31'h0, st_done}, 0);
      while (!st_done && i < 40) begin
        logic [1:0] ch; logic [11:0] d; logic o;
        ch = 2'(i % 4); d = seed + 12'(i); o = (8'(i) == ori);
        if (en[ch] && taken < int'(cnt)) begin
          exp_w[exp_n] = {2'b00, ch, d}; exp_n++; taken++;
          if (o) exp_or = 1'b1;
        end
        send(ch, d, o);
        i++;
      end
      repeat (6) step();
      @(negedge clk);
      chk("R4 words captured", rx_n, exp_n);
      chk("R4 done", {31'h0, st_done}, 1);
      chk("R4 busy low", {31'h0, st_busy}, 0);
      chk("R8 orng", {31'h0, st_orng}, {31'h0, exp_or});
      chk("R7 no ovf", {31'h0, st_ovf}, 0);
    end

    // R5 zero count
    start(16'd0, 4'hF);
    @(negedge clk);
    chk("R5 done", {31'h0, st_done}, 1);
    chk("R5 busy", {31'h0, st_busy}, 0);

    // R3 samples while idle ignored
    send(2'd0, 12'h123, 1'b1);
    send(2'd1, 12'h456, 1'b0);
    @(negedge clk);
    chk("R3 idle no write", {31'h0, m_valid}, 0);
    chk("R8 idle or ignored", {31'h0, st_orng}, 0);

    // R6 start while busy ignored, R3 dsel-low ignored
    start(16'd2, 4'h1);
    cmd_start = 1'b1; cmd_count = 16'd9; cmd_ch_en = 4'hF;
    step();
    cmd_start = 1'b0;
    send(2'd1, 12'h111, 1'b1);
    exp_w[exp_n] = 16'h00AA; exp_n++;
    send(2'd0, 12'h0AA, 1'b0);
    adc_ch = 2'd0; adc_data = 12'h555; adc_dsel = 1'b0;
    step();
    exp_w[exp_n] = 16'h00BB; exp_n++;
    send(2'd0, 12'h0BB, 1'b0);
    repeat (4) step();
    @(negedge clk);
    chk("R6 done after two", {31'h0, st_done}, 1);
    chk("R6 words", rx_n, exp_n);
    chk("R8 disabled or ignored", {31'h0, st_orng}, 0);

    // R7 overflow, R10 latency, R9 hold
    m_ready = 1'b0;
    start(16'd10, 4'hF);
    adc_ch = 2'd0; adc_data = 12'h200; adc_dsel = 1'b1;
    @(negedge clk);
    chk("R10 not before edge", {31'h0, m_valid}, 0);
    step();
    adc_dsel = 1'b0;
    @(negedge clk);
    chk("R10 valid after edge", {31'h0, m_valid}, 1);
    chk("R10 data after edge", {16'h0, m_data}, 32'h0200);
    exp_w[exp_n] = 16'h0200; exp_n++;
    step();
    for (int i = 1; i < 10; i++) begin
      if (i < 8) begin exp_w[exp_n] = {2'b00, 2'(i % 4), 12'h200 + 12'(i)}; exp_n++; end
      send(2'(i % 4), 12'h200 + 12'(i), 1'b0);
    end
    @(negedge clk);
    chk("R7 ovf set", {31'h0, st_ovf}, 1);
    chk("R4 done with drops", {31'h0, st_done}, 1);
    chk("R9 head held", {16'h0, m_data}, 32'h0200);
    repeat (3) step();
    settle_check("R7 ovf sticky", {31'h0, st_ovf}, 1);
    m_ready = 1'b1;
    repeat (12) step();
    @(negedge clk);
    chk("R7 dropped not retried", rx_n, exp_n);
    chk("R7 fifo empty", {31'h0, m_valid}, 0);

    // R2 new start clears sticky flags
    start(16'd0, 4'hF);
    @(negedge clk);
    chk("R2 ovf cleared", {31'h0, st_ovf}, 0);
    chk("R2 done", {31'h0, st_done}, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule